// File: doc/BRIEF.md
# RAM and Streaming I/O Address Decoder

This block sits between a small core's word-wide memory port and the storage behind it. It owns a word RAM that covers byte addresses from 0x000 up to, but not including, 0x7fc. The single aligned word at 0x7fc is not storage: it is a streaming I/O port. A load from it takes the next word from an input stream, and a store to it hands one word to an output stream. Both streams use a valid/ready handshake. Every other address, and any address that is not a multiple of four, is an invalid access.

The core issues one request at a time with `req_valid`. The block holds `req_ready` low while an I/O access waits for its stream partner. Each accepted access yields a one-cycle `rsp_valid` pulse on the next cycle. Because each I/O load consumes a fresh input word, a program can read a whole sequence by loading the same address again and again. Invalid accesses finish at once, return zero and set a sticky error flag. A preload port lets a test bench fill RAM words before the core runs.

Top module: `memio_bridge`

## Requirements
- R1: A load from an aligned address below 0x7fc is accepted in the cycle it is requested (`req_ready` high), and the stored word appears on `rsp_rdata` with `rsp_valid` high one cycle after the accepting edge.
- R2: A store to an aligned address below 0x7fc is accepted at once and updates the RAM word on the accepting edge, so a load accepted on any later edge returns it.
- R3: A load from 0x7fc holds `req_ready` low until `in_valid` is high. `in_ready` is high only while that load is requested. The word taken on the handshake edge is returned one cycle later, and successive loads return successive stream words.
- R4: A store to 0x7fc drives `out_valid` with `out_data` equal to the store data, and holds `req_ready` low until `out_ready` is high, giving exactly one output transfer per store.
- R5: An aligned access at or above 0x800 completes at once, returns zero, sets `err_flag` on the next cycle, and leaves every RAM word unchanged.
- R6: An access whose address has bits [1:0] not equal to zero is invalid whatever its range: it completes at once, sets `err_flag`, and leaves the RAM unchanged.
- R7: `err_flag` stays high once set until reset.
- R8: After reset, `rsp_valid`, `err_flag`, `in_ready` and `out_valid` are low and `req_ready` is high. RAM contents are not cleared by reset.
- R9: While `preload_we` is high, the word at index `preload_idx` (byte address = 4 × index) takes `preload_data` on the clock edge, and `req_ready` is low.
- R10: An accepted store of any kind answers with `rsp_valid` high and `rsp_rdata` zero one cycle later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Access requested |
| req_write | input | 1 | 1 = store, 0 = load |
| req_addr | input | 32 | Byte address |
| req_wdata | input | 32 | Store data |
| req_ready | output | 1 | Access accepted on this edge when high with req_valid |
| rsp_valid | output | 1 | One-cycle pulse after each accepted access |
| rsp_rdata | output | 32 | Load result, zero for stores and invalid accesses |
| err_flag | output | 1 | Sticky invalid-access flag |
| in_valid | input | 1 | Input stream word available |
| in_data | input | 32 | Input stream word |
| in_ready | output | 1 | Input word taken when high with in_valid |
| out_valid | output | 1 | Output stream word offered |
| out_data | output | 32 | Output stream word |
| out_ready | input | 1 | Output consumer ready |
| preload_we | input | 1 | Test preload write enable |
| preload_idx | input | 9 | Test preload word index |
| preload_data | input | 32 | Test preload word |

## Verification
Stream handshake signals (`req_ready`, `in_ready`, `out_valid`, `out_data`) follow the request in the same cycle, so the bench reads them a moment after the falling edge on which it drives the request. Load data, `rsp_valid` and the error flag are registered: they change on the edge that accepts the access, so the bench reads them after the next falling edge, one full cycle after driving. Stream transfers are counted by the bench on the rising edge where both valid and ready are high, which tells apart a stall from a consumed word.

// File: rtl/memio_pkg.sv
package memio_pkg;
  typedef enum logic [1:0] {
    TGT_RAM = 2'd0,
    TGT_IO  = 2'd1,
    TGT_BAD = 2'd2
  } tgt_e;
endpackage

// File: rtl/memio_decode.sv
module memio_decode
  import memio_pkg::*;
#(
  parameter int AW = 32,
  parameter logic [AW-1:0] IO_ADDR = 'h7FC
) (
  input  logic [AW-1:0] addr,
  output tgt_e          tgt
);
  always_comb begin
    if (addr[1:0] != 2'b00)   tgt = TGT_BAD;
    else if (addr == IO_ADDR) tgt = TGT_IO;
    else if (addr < IO_ADDR)  tgt = TGT_RAM;
    else                      tgt = TGT_BAD;
  end
endmodule

// File: rtl/memio_ram.sv
module memio_ram #(
  parameter int DW    = 32,
  parameter int DEPTH = 511,
  parameter int IW    = 9
) (
  input  logic          clk,
  input  logic          we,
  input  logic [IW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [IW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/memio_stream.sv
module memio_stream #(
  parameter int DW = 32
) (
  input  logic          req_valid,
  input  logic          req_write,
  input  logic          is_io,
  input  logic [DW-1:0] wdata,
  input  logic          in_valid,
  input  logic          out_ready,
  output logic          in_ready,
  output logic          out_valid,
  output logic [DW-1:0] out_data,
  output logic          io_ready
);
  logic io_rd, io_wr;

  always_comb begin
    io_rd     = req_valid && is_io && !req_write;
    io_wr     = req_valid && is_io && req_write;
    in_ready  = io_rd;
    out_valid = io_wr;
    out_data  = wdata;
    io_ready  = req_write ? out_ready : in_valid;
  end
endmodule

// File: rtl/memio_bridge.sv
module memio_bridge
  import memio_pkg::*;
#(
  parameter int AW = 32,
  parameter int DW = 32,
  parameter logic [AW-1:0] IO_ADDR = 'h7FC
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          req_valid,
  input  logic          req_write,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  output logic          req_ready,
  output logic          rsp_valid,
  output logic [DW-1:0] rsp_rdata,
  output logic          err_flag,
  input  logic          in_valid,
  input  logic [DW-1:0] in_data,
  output logic          in_ready,
  output logic          out_valid,
  output logic [DW-1:0] out_data,
  input  logic          out_ready,
  input  logic          preload_we,
  input  logic [8:0]    preload_idx,
  input  logic [DW-1:0] preload_data
);
  localparam int RAM_WORDS = int'(IO_ADDR >> 2);
  localparam int IW        = $clog2(RAM_WORDS);

  tgt_e          tgt;
  logic          io_ready, accept, ram_we;
  logic [IW-1:0] word_idx, ram_waddr;
  logic [DW-1:0] ram_wdata, ram_q, hold_q;
  logic          sel_ram_q;

  memio_decode #(.AW(AW), .IO_ADDR(IO_ADDR)) u_dec (
    .addr (req_addr),
    .tgt  (tgt)
  );

  memio_stream #(.DW(DW)) u_stream (
    .req_valid (req_valid),
    .req_write (req_write),
    .is_io     (tgt == TGT_IO),
    .wdata     (req_wdata),
    .in_valid  (in_valid),
    .out_ready (out_ready),
    .in_ready  (in_ready),
    .out_valid (out_valid),
    .out_data  (out_data),
    .io_ready  (io_ready)
  );

  always_comb begin
    word_idx  = req_addr[IW+1:2];
    req_ready = !preload_we && ((tgt != TGT_IO) || io_ready);
    accept    = req_valid && req_ready;
    ram_we    = preload_we || (accept && req_write && tgt == TGT_RAM);
    ram_waddr = preload_we ? preload_idx[IW-1:0] : word_idx;
    ram_wdata = preload_we ? preload_data : req_wdata;
  end

  memio_ram #(.DW(DW), .DEPTH(RAM_WORDS), .IW(IW)) u_ram (
    .clk   (clk),
    .we    (ram_we),
    .waddr (ram_waddr),
    .wdata (ram_wdata),
    .raddr (word_idx),
    .rdata (ram_q)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid <= 1'b0;
      sel_ram_q <= 1'b0;
      hold_q    <= '0;
      err_flag  <= 1'b0;
    end else begin
      rsp_valid <= accept;
      sel_ram_q <= accept && !req_write && tgt == TGT_RAM;
      hold_q    <= (accept && !req_write && tgt == TGT_IO) ? in_data : '0;
      if (accept && tgt == TGT_BAD) err_flag <= 1'b1;
    end
  end

  assign rsp_rdata = sel_ram_q ? ram_q : hold_q;
endmodule

// File: rtl/memio_checker.sv
module memio_checker #(
  parameter int AW = 32,
  parameter int DW = 32,
  parameter logic [AW-1:0] IO_ADDR = 'h7FC
) (
  input logic          clk,
  input logic          rst,
  input logic          req_valid,
  input logic          req_write,
  input logic [AW-1:0] req_addr,
  input logic          req_ready,
  input logic          rsp_valid,
  input logic [DW-1:0] rsp_rdata,
  input logic          err_flag,
  input logic          in_valid,
  input logic          in_ready,
  input logic          out_valid,
  input logic          out_ready,
  input logic          preload_we
);
  p_rsp_after_accept_r1: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready) |=> rsp_valid);

  p_io_read_stall_r3: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !req_write && req_addr == IO_ADDR && !in_valid) |-> !req_ready);

  p_in_ready_scope_r3: assert property (@(posedge clk) disable iff (rst)
    in_ready |-> (req_valid && !req_write && req_addr == IO_ADDR));

  p_out_valid_scope_r4: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (req_valid && req_write && req_addr == IO_ADDR));

  p_out_stall_r4: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |-> !req_ready);

  p_bad_read_zero_r5: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready && !req_write && req_addr > IO_ADDR && req_addr[1:0] == 2'b00)
    |=> (rsp_rdata == '0 && err_flag));

  p_misaligned_err_r6: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready && req_addr[1:0] != 2'b00) |=> err_flag);

  p_err_sticky_r7: assert property (@(posedge clk) disable iff (rst)
    err_flag |=> err_flag);

  p_preload_blocks_r9: assert property (@(posedge clk) disable iff (rst)
    preload_we |-> !req_ready);
endmodule

bind memio_bridge memio_checker #(.AW(AW), .DW(DW), .IO_ADDR(IO_ADDR)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .req_valid  (req_valid),
  .req_write  (req_write),
  .req_addr   (req_addr),
  .req_ready  (req_ready),
  .rsp_valid  (rsp_valid),
  .rsp_rdata  (rsp_rdata),
  .err_flag   (err_flag),
  .in_valid   (in_valid),
  .in_ready   (in_ready),
  .out_valid  (out_valid),
  .out_ready  (out_ready),
  .preload_we (preload_we)
);

// File: tb/sim_memio_bridge.sv
`timescale 1ns/1ps
module sim_memio_bridge;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0, req_write = 1'b0;
  logic [31:0] req_addr = '0, req_wdata = '0;
  logic        req_ready, rsp_valid, err_flag, in_ready, out_valid;
  logic [31:0] rsp_rdata, out_data, in_data;
  logic        in_valid, out_ready = 1'b0;
  logic        preload_we = 1'b0;
  logic [8:0]  preload_idx = '0;
  logic [31:0] preload_data = '0;

  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  // input stream feeder: advances on each handshake edge
  logic [31:0] feed [4] = '{32'h0000_0101, 32'h0000_0202, 32'h0000_0303, 32'h0000_0404};
  int  feed_idx = 0;
  bit  feed_en  = 1'b0;
  assign in_valid = feed_en && feed_idx < 4;
  assign in_data  = feed[feed_idx[1:0]];
  always @(posedge clk) if (in_valid && in_ready) feed_idx <= feed_idx + 1;

  // output stream sink
  int          sink_cnt = 0;
  logic [31:0] sink_data = '0;
  always @(posedge clk) if (out_valid && out_ready) begin
    sink_cnt  <= sink_cnt + 1;
    sink_data <= out_data;
  end

  memio_bridge u0 (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .req_ready(req_ready),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .err_flag(err_flag),
    .in_valid(in_valid), .in_data(in_data), .in_ready(in_ready),
    .out_valid(out_valid), .out_data(out_data), .out_ready(out_ready),
    .preload_we(preload_we), .preload_idx(preload_idx), .preload_data(preload_data)
  );

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // drive on falling edge, wait for acceptance, sample response one cycle later
  task automatic access(input bit we, input logic [31:0] a, input logic [31:0] d,
                        output bit rv, output logic [31:0] rd);
    @(negedge clk);
    req_valid = 1'b1; req_write = we; req_addr = a; req_wdata = d;
    #1;
    while (!req_ready) begin @(negedge clk); #1; end
    @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0;
    #1;
    rv = rsp_valid; rd = rsp_rdata;
  endtask

  // {write, addr, wdata, expected rdata}
  localparam logic [96:0] VEC [7] = '{
    {1'b1, 32'h0000_0000, 32'h1111_1111, 32'h0000_0000},
    {1'b0, 32'h0000_0000, 32'h0000_0000, 32'h1111_1111},
    {1'b1, 32'h0000_07F8, 32'hA5A5_A5A5, 32'h0000_0000},
    {1'b0, 32'h0000_07F8, 32'h0000_0000, 32'hA5A5_A5A5},
    {1'b0, 32'h0000_0020, 32'h0000_0000, 32'h0000_002A},
    {1'b1, 32'h0000_0004, 32'hDEAD_BEEF, 32'h0000_0000},
    {1'b0, 32'h0000_0004, 32'h0000_0000, 32'hDEAD_BEEF}
  };

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    bit rv;
    logic [31:0] rd;

    repeat (3) @(negedge clk);
    rst = 1'b0;
    #1;
    // R8 reset state
    check(!rsp_valid && !err_flag && !in_ready && !out_valid, "R8 reset outputs",
          {28'd0, rsp_valid, err_flag, in_ready, out_valid}, 32'd0);
    check(req_ready, "R8 ready after reset", {31'd0, req_ready}, 32'd1);

    // R9 preload words 8 and 9
    @(negedge clk);
    preload_we = 1'b1; preload_idx = 9'd8; preload_data = 32'd42;
    #1;
    check(!req_ready, "R9 ready low during preload", {31'd0, req_ready}, 32'd0);
    @(negedge clk);
    preload_idx = 9'd9; preload_data = 32'd13;
    @(negedge clk);
    preload_we = 1'b0;

    // R1 R2 R10 vector walk
    foreach (VEC[i]) begin
      access(VEC[i][96], VEC[i][95:64], VEC[i][63:32], rv, rd);
      check(rv && rd == VEC[i][31:0], VEC[i][96] ? "R10 R2 store response" : "R1 load data", rd, VEC[i][31:0]);
    end
    access(1'b0, 32'h24, '0, rv, rd);
    check(rd == 32'd13, "R9 preload word 9", rd, 32'd13);
    check(!err_flag, "R1 no error on valid accesses", {31'd0, err_flag}, 32'd0);

    // R3 I/O load stalls until input valid
    fork
      access(1'b0, 32'h7FC, '0, rv, rd);
      begin
        repeat (3) @(negedge clk);
        #2;
        check(!req_ready && in_ready, "R3 stall while no input", {30'd0, req_ready, in_ready}, 32'd1);
        @(negedge clk);
        feed_en = 1'b1;
      end
    join
    check(rv && rd == 32'h0101, "R3 first stream word", rd, 32'h0101);
    access(1'b0, 32'h7FC, '0, rv, rd);
    check(rd == 32'h0202, "R3 second stream word", rd, 32'h0202);
    check(feed_idx == 2 && !in_ready, "R3 two words consumed", feed_idx, 32'd2);

    // R4 I/O store stalls until output ready
    fork
      access(1'b1, 32'h7FC, 32'hCAFE_0001, rv, rd);
      begin
        repeat (2) @(negedge clk);
        #2;
        check(out_valid && out_data == 32'hCAFE_0001 && !req_ready, "R4 offered while stalled", out_data, 32'hCAFE_0001);
        check(sink_cnt == 0, "R4 no transfer before ready", sink_cnt, 32'd0);
        @(negedge clk);
        out_ready = 1'b1;
      end
    join
    check(sink_cnt == 1 && sink_data == 32'hCAFE_0001, "R4 one transfer", sink_data, 32'hCAFE_0001);
    check(!out_valid && rv && rd == 0, "R4 R10 store done", rd, 32'd0);
    out_ready = 1'b0;

    // R5 invalid addresses
    access(1'b1, 32'h0000_0800, 32'h5555_5555, rv, rd);
    check(rv && rd == 0 && err_flag, "R5 invalid store", {31'd0, err_flag}, 32'd1);
    access(1'b0, 32'hFFFF_FFFC, '0, rv, rd);
    check(rd == 0, "R5 invalid load zero", rd, 32'd0);
    access(1'b0, 32'h0000_0000, '0, rv, rd);
    check(rd == 32'h1111_1111, "R5 RAM unchanged", rd, 32'h1111_1111);
    check(err_flag, "R7 error sticky", {31'd0, err_flag}, 32'd1);

    // reset clears flag, RAM retained; R6 misaligned
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    #1;
    check(!err_flag, "R8 reset clears error", {31'd0, err_flag}, 32'd0);
    access(1'b1, 32'h0000_0005, 32'h7777_7777, rv, rd);
    check(rv && err_flag, "R6 misaligned flagged", {31'd0, err_flag}, 32'd1);
    access(1'b0, 32'h0000_0004, '0, rv, rd);
    check(rd == 32'hDEAD_BEEF, "R6 RAM unchanged", rd, 32'hDEAD_BEEF);
    access(1'b0, 32'h0000_07FE, '0, rv, rd);
    check(rd == 0 && feed_idx == 2, "R6 misaligned near port", rd, 32'd0);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule